// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block is the next-address engine of a small processor with a 12-bit instruction address. It holds the program counter and a hardware stack of return addresses. Each time the core finishes an instruction it pulses a step strobe. On that strobe the block picks the next address from one of five sources: plus one, a relative branch on the zero or carry flag, an absolute jump, a subroutine call, or a return.

The decoder supplies the instruction class, the branch condition selector, a signed displacement, an absolute target and the two flags. A call stores the address that follows the call on the stack and then goes to the target. A return goes back to the address stored most recently. Calls can nest up to the stack depth. When the stack is already full, the oldest stored address is lost and an overflow flag is raised. A return on an empty stack goes to address 0 and raises an underflow flag.

Every pin is a plain control or status pin. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. The strobe is always accepted in the cycle it is high.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc_o` is 0, `depth_o` is 0, `stk_empty_o` is 1, and `stk_full_o`, `stk_ovf_o` and `stk_unf_o` are 0.
- R2: `pc_o` and the stack change only at a clock edge where `step_i` is 1. With `step_i` at 0, every other input is ignored and `pc_o` holds its value.
- R3: Class code 0 (sequential), and the unused codes 5, 6 and 7, load `pc_o + 1` modulo 4096.
- R4: Class code 1 is a branch. `cond_sel_i` picks the condition: 0 means taken when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0. A taken branch loads `pc_o + 1 + disp`, where `disp_i` is sign-extended from 8 bits and the sum wraps modulo 4096. A branch that is not taken loads `pc_o + 1`.
- R5: Class code 2 is a jump. It loads `target_i`.
- R6: Class code 3 is a call. It pushes `pc_o + 1`, loads `target_i`, and increments `depth_o` when the stack is not full.
- R7: Class code 4 is a return. On a non-empty stack it loads the most recently pushed address and decrements `depth_o`. Nested calls come back in last-in, first-out order.
- R8: A call while `depth_o` is 8 drops the oldest entry and keeps `depth_o` at 8. It also sets `stk_ovf_o`. The next eight returns then give the eight newest addresses, newest first.
- R9: A return while `depth_o` is 0 loads 0, keeps `depth_o` at 0 and sets `stk_unf_o`.
- R10: `stk_ovf_o` and `stk_unf_o` show only the most recent step, and the next step that does not cause them clears them. `stk_full_o` is 1 exactly when `depth_o` is 8. `stk_empty_o` is 1 exactly when `depth_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One instruction retires this cycle |
| kind_i | input | 3 | Instruction class: 0 seq, 1 branch, 2 jump, 3 call, 4 return |
| cond_sel_i | input | 2 | Branch condition: 0 Z set, 1 Z clear, 2 C set, 3 C clear |
| disp_i | input | 8 | Signed branch displacement |
| target_i | input | 12 | Absolute jump or call address |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| pc_o | output | 12 | Program counter |
| depth_o | output | 4 | Number of stored return addresses |
| stk_empty_o | output | 1 | Stack holds no entry |
| stk_full_o | output | 1 | Stack holds the maximum number of entries |
| stk_ovf_o | output | 1 | Last step pushed onto a full stack |
| stk_unf_o | output | 1 | Last step popped an empty stack |

## Verification
The bench builds the block with its default parameters: a 12-bit address, an 8-bit displacement and a stack of depth 8.

- The 12-bit address lets a single jump to 0xFFF followed by one sequential step show the wrap to 0.
- The 8-bit displacement lets the most negative offset, -128, wrap the PC backwards past 0.
- The depth of 8 means nine nested calls are enough to reach overflow, and the full unwind that follows reaches underflow.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    K_SEQ  = 3'd0,
    K_BRA  = 3'd1,
    K_JMP  = 3'd2,
    K_CALL = 3'd3,
    K_RET  = 3'd4
  } kind_t;

  typedef enum logic [1:0] {
    C_ZSET = 2'd0,
    C_ZCLR = 2'd1,
    C_CSET = 2'd2,
    C_CCLR = 2'd3
  } cond_t;
endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
  import pcseq_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       z_i,
  input  logic       c_i,
  output logic       hit_o
);
  always_comb begin
    unique case (cond_t'(sel_i))
      C_ZSET:  hit_o = z_i;
      C_ZCLR:  hit_o = !z_i;
      C_CSET:  hit_o = c_i;
      default: hit_o = !c_i;
    endcase
  end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8
) (
  input  logic [2:0]        kind_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              push_o,
  output logic              pop_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] sext;

  assign inc        = pc_i + ADDR_W'(1);
  assign sext       = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ret_addr_o = inc;

  always_comb begin
    next_o = inc;
    push_o = 1'b0;
    pop_o  = 1'b0;
    unique case (kind_t'(kind_i))
      K_BRA:  if (taken_i) next_o = inc + sext;
      K_JMP:  next_o = target_i;
      K_CALL: begin
        next_o = target_i;
        push_o = 1'b1;
      end
      K_RET: begin
        next_o = pop_addr_i;
        pop_o  = 1'b1;
      end
      default: next_o = inc;
    endcase
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp;
  logic [CNT_W-1:0]  cnt;
  logic [PTR_W-1:0]  wp_prev;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH-1) : p - PTR_W'(1);
  endfunction

  assign wp_prev    = ptr_dn(wp);
  assign empty_o    = (cnt == '0);
  assign full_o     = (cnt == CNT_W'(DEPTH));
  assign count_o    = cnt;
  assign top_addr_o = empty_o ? '0 : mem[wp_prev];

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= push_addr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push_i) begin
      wp <= ptr_up(wp);
      if (!full_o) cnt <= cnt + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      wp  <= wp_prev;
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DISP_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [2:0]        kind_i,
  input  logic [1:0]        cond_sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic              stk_empty_o,
  output logic              stk_full_o,
  output logic              stk_ovf_o,
  output logic              stk_unf_o
);
  logic              taken;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] ret_addr;
  logic [ADDR_W-1:0] top_addr;
  logic              push_req, pop_req;
  logic              push_en, pop_en;
  logic [ADDR_W-1:0] pc_q;
  logic              ovf_q, unf_q;

  pcseq_cond u_cond (
    .sel_i (cond_sel_i),
    .z_i   (flag_z_i),
    .c_i   (flag_c_i),
    .hit_o (taken)
  );

  pcseq_next #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_next (
    .kind_i     (kind_i),
    .taken_i    (taken),
    .pc_i       (pc_q),
    .disp_i     (disp_i),
    .target_i   (target_i),
    .pop_addr_i (top_addr),
    .next_o     (next_pc),
    .ret_addr_o (ret_addr),
    .push_o     (push_req),
    .pop_o      (pop_req)
  );

  assign push_en = step_i && push_req;
  assign pop_en  = step_i && pop_req;

  pcseq_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_en),
    .pop_i       (pop_en),
    .push_addr_i (ret_addr),
    .top_addr_o  (top_addr),
    .count_o     (depth_o),
    .full_o      (stk_full_o),
    .empty_o     (stk_empty_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (step_i) begin
      pc_q  <= next_pc;
      ovf_q <= push_req && stk_full_o;
      unf_q <= pop_req && stk_empty_o;
    end
  end

  assign pc_o      = pc_q;
  assign stk_ovf_o = ovf_q;
  assign stk_unf_o = unf_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic [2:0]        kind_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [$clog2(DEPTH+1)-1:0] depth_o,
  input logic              stk_empty_o,
  input logic              stk_full_o,
  input logic              stk_ovf_o,
  input logic              stk_unf_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(pc_o) && $stable(depth_o)));

  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 3'd0) |=> pc_o == $past(pc_o) + ADDR_W'(1));

  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 3'd2) |=> pc_o == $past(target_i));

  p_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 3'd3 && !stk_full_o)
      |=> (depth_o == $past(depth_o) + CNT_W'(1) && pc_o == $past(target_i)));

  p_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 3'd3 && stk_full_o) |=> (stk_ovf_o && stk_full_o));

  p_unf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 3'd4 && stk_empty_o)
      |=> (stk_unf_o && pc_o == '0 && stk_empty_o));

  p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_ovf_o && stk_unf_o));

  p_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full_o == (depth_o == CNT_W'(DEPTH)));
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .kind_i      (kind_i),
  .target_i    (target_i),
  .pc_o        (pc_o),
  .depth_o     (depth_o),
  .stk_empty_o (stk_empty_o),
  .stk_full_o  (stk_full_o),
  .stk_ovf_o   (stk_ovf_o),
  .stk_unf_o   (stk_unf_o)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [1:0]  cond_sel_i = '0;
  logic [7:0]  disp_i = '0;
  logic [11:0] target_i = '0;
  logic        flag_z_i = 1'b0;
  logic        flag_c_i = 1'b0;
  logic [11:0] pc_o;
  logic [3:0]  depth_o;
  logic        stk_empty_o, stk_full_o, stk_ovf_o, stk_unf_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .kind_i(kind_i),
    .cond_sel_i(cond_sel_i), .disp_i(disp_i), .target_i(target_i),
    .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .pc_o(pc_o),
    .depth_o(depth_o), .stk_empty_o(stk_empty_o), .stk_full_o(stk_full_o),
    .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
  );

  // entry: {kind[3], cond[2], disp[8], target[12], z, c, exp_pc[12], exp_depth[4]}
  localparam int NV = 15;
  localparam logic [42:0] VEC [NV] = '{
    {3'd0, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0, 12'h001, 4'd0}, // R3 seq
    {3'd1, 2'd0, 8'h01, 12'h000, 1'b1, 1'b0, 12'h003, 4'd0}, // R4 bz taken, skip one
    {3'd1, 2'd0, 8'h05, 12'h000, 1'b0, 1'b0, 12'h004, 4'd0}, // R4 bz not taken
    {3'd1, 2'd1, 8'hFC, 12'h000, 1'b0, 1'b0, 12'h001, 4'd0}, // R4 bnz back -4
    {3'd1, 2'd2, 8'h10, 12'h000, 1'b0, 1'b1, 12'h012, 4'd0}, // R4 bc taken
    {3'd1, 2'd3, 8'h09, 12'h000, 1'b0, 1'b1, 12'h013, 4'd0}, // R4 bnc not taken
    {3'd2, 2'd0, 8'h00, 12'h100, 1'b0, 1'b0, 12'h100, 4'd0}, // R5 jump
    {3'd3, 2'd0, 8'h00, 12'h200, 1'b0, 1'b0, 12'h200, 4'd1}, // R6 call
    {3'd3, 2'd0, 8'h00, 12'h300, 1'b0, 1'b0, 12'h300, 4'd2}, // R6 nested call
    {3'd4, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0, 12'h201, 4'd1}, // R7 return inner
    {3'd4, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0, 12'h101, 4'd0}, // R7 return outer
    {3'd2, 2'd0, 8'h00, 12'hFFF, 1'b0, 1'b0, 12'hFFF, 4'd0}, // R5 jump to top
    {3'd0, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0, 12'h000, 4'd0}, // R3 wrap
    {3'd1, 2'd3, 8'h80, 12'h000, 1'b0, 1'b0, 12'hF81, 4'd0}, // R4 bnc -128 wraps
    {3'd7, 2'd0, 8'h00, 12'h555, 1'b1, 1'b1, 12'hF82, 4'd0}  // R3 unused code
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_step(input logic [2:0] k, input logic [1:0] cs,
                         input logic [7:0] d, input logic [11:0] t,
                         input logic z, input logic c);
    @(negedge clk);
    kind_i = k; cond_sel_i = cs; disp_i = d; target_i = t;
    flag_z_i = z; flag_c_i = c; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 pc", pc_o, 0);
    check("R1 depth", depth_o, 0);
    check("R1 empty", stk_empty_o, 1);
    check("R1 flags", {stk_full_o, stk_ovf_o, stk_unf_o}, 0);

    for (int i = 0; i < NV; i++) begin
      do_step(VEC[i][42:40], VEC[i][39:38], VEC[i][37:30], VEC[i][29:18],
              VEC[i][17], VEC[i][16]);
      check($sformatf("R3/R4/R5/R6/R7 vec %0d pc", i), pc_o, int'(VEC[i][15:4]));
      check($sformatf("R6/R7 vec %0d depth", i), depth_o, int'(VEC[i][3:0]));
    end

    // R2: inputs ignored without step
    @(negedge clk);
    kind_i = 3'd2; target_i = 12'h0AA; step_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 hold pc", pc_o, 12'hF82);
    kind_i = 3'd3;
    repeat (2) @(negedge clk);
    check("R2 hold depth", depth_o, 0);

    // R8: overflow
    do_step(3'd2, 2'd0, 8'h00, 12'h010, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      do_step(3'd3, 2'd0, 8'h00, 12'((i + 1) * 12'h100), 1'b0, 1'b0);
    check("R10 full", stk_full_o, 1);
    check("R8 no ovf yet", stk_ovf_o, 0);
    check("R8 depth 8", depth_o, 8);
    do_step(3'd3, 2'd0, 8'h00, 12'h900, 1'b0, 1'b0);
    check("R8 ovf set", stk_ovf_o, 1);
    check("R8 depth stays", depth_o, 8);
    check("R8 pc", pc_o, 12'h900);
    for (int i = 8; i >= 1; i--) begin
      do_step(3'd4, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0);
      check($sformatf("R8 pop order %0d", i), pc_o, i * 12'h100 + 1);
      if (i == 8) check("R10 ovf cleared", stk_ovf_o, 0);
    end
    check("R10 empty", stk_empty_o, 1);

    // R9: underflow
    do_step(3'd4, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0);
    check("R9 pc zero", pc_o, 0);
    check("R9 unf set", stk_unf_o, 1);
    check("R9 depth", depth_o, 0);
    do_step(3'd0, 2'd0, 8'h00, 12'h000, 1'b0, 1'b0);
    check("R10 unf cleared", stk_unf_o, 0);
    check("R3 after unf", pc_o, 1);

    // R1: reset mid-run
    do_step(3'd3, 2'd0, 8'h00, 12'h777, 1'b0, 1'b0);
    do_reset();
    check("R1 reset pc", pc_o, 0);
    check("R1 reset depth", depth_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule